// File: doc/BRIEF.md
# Grouped Masked Interrupt Aggregator

This block gathers interrupt events from a bank of general-purpose input pins and from a keyboard-scan event strobe. It latches them into sticky status registers and drives a single active-low interrupt request. The pins are organised in groups of `REG_W` bits. Each pin is synchronised, and a per-pin control bit picks whether a rising or a falling edge counts as an event. The keyboard strobes form one extra group. They are already synchronous to `clk`, and every high cycle on a strobe bit is an event.

Each group has a status register that software clears by writing ones, and a mask register that enables it. A summary register has one bit per group, and that bit is set while the group holds a status bit whose mask bit is also set. Software reads the summary first, then reads the status and mask of the flagged group. A simple synchronous read/write port reaches all registers.

Address map (5-bit address, the top two bits select the register kind). GPIO group g (g = 0..2) covers pins 8g..8g+7, and pin p sits in bit p%8.

| Address | Register |
|---------|----------|
| g | status of GPIO group g |
| 3 | keyboard status |
| 8 + g | mask of GPIO group g |
| 11 | keyboard mask |
| 16 + g | edge select of GPIO group g |
| 24 | summary, read only (bits 0..2 are the GPIO groups, bit 3 is the keyboard) |

Every other address reads as zero and ignores writes.

Top module: `irq_group_agg`

## Requirements
- R1: After a synchronous reset, all status, mask and edge-select registers read 0, `irq_n` is 1 and `rd_valid` is 0.
- R2: With its edge-select bit at 0, a rising edge on pin p sets status bit p%8 of GPIO group p/8 (address p/8). A falling edge on that pin sets nothing.
- R3: With its edge-select bit at 1, a falling edge on the pin sets its status bit and a rising edge sets nothing.
- R4: A cycle with `kbd_evt` bit i high sets bit i of the keyboard status register (address 3), and leaves the GPIO status registers untouched.
- R5: A write to a status address clears every bit written as 1 and leaves every bit written as 0 unchanged. A status bit never becomes 1 without an event.
- R6: If an event and a clearing write hit the same status bit in the same cycle, the bit stays 1.
- R7: `irq_n` is 0 exactly when, in the previous cycle, some status bit and its matching mask bit were both 1. Set status bits that are masked do not assert it.
- R8: Summary bit g (address 24) reads 1 exactly when status and mask of group g share a set bit. Bits 0..2 are the GPIO groups and bit 3 is the keyboard group.
- R9: Mask and edge-select registers read back the last written value. The summary and all unmapped addresses read 0, and writes to them have no effect.
- R10: Read data appears with `rd_valid` high one cycle after `rd_en`. A pin edge sets its status bit on the third rising clock edge after the pin changes, and `irq_n` follows on the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | 24 | Asynchronous general-purpose pins, group g in bits 8g+7..8g |
| kbd_evt | input | 8 | Synchronous keyboard-scan event strobes |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | High when `rd_data` holds the answer to the read of the previous cycle |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
A write changes state on the clock edge that samples it. A read returns the state of that same edge one cycle later. `irq_n` trails any status or mask change by one more edge. A pin change passes two synchroniser flops and the status flop, so its status bit is set three edges later and `irq_n` four edges later. The bench drives on falling edges, samples on falling edges, and waits these exact counts before each check. For latency, it checks `irq_n` both one cycle before and in the cycle it is due. Reads go into a scoreboard queue with the value the requirements predict at the sampling edge. A monitor pops each entry when `rd_valid` rises, so every read result is compared in the cycle it becomes valid.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Address layout: [ADDR_W-1 -: KIND_W] selects the register kind,
  // the low GRP_IDX_W bits select the group.
  localparam int unsigned GRP_IDX_W = 3;
  localparam int unsigned KIND_W    = 2;
  localparam int unsigned ADDR_W    = KIND_W + GRP_IDX_W;

  typedef enum logic [KIND_W-1:0] {
    K_STAT = 2'd0,
    K_MASK = 2'd1,
    K_EDGE = 2'd2,
    K_SUMM = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic                 hit;
    reg_kind_e            kind;
    logic [GRP_IDX_W-1:0] grp;
  } reg_sel_t;

  // Status and mask exist for n_gpio GPIO groups plus the keyboard group,
  // edge select only for GPIO groups, summary only at group index 0.
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                           input int unsigned       n_gpio);
    reg_sel_t s;
    s.kind = reg_kind_e'(a[ADDR_W-1 -: KIND_W]);
    s.grp  = a[GRP_IDX_W-1:0];
    unique case (s.kind)
      K_STAT, K_MASK: s.hit = (32'(s.grp) <= n_gpio);
      K_EDGE:         s.hit = (32'(s.grp) <  n_gpio);
      default:        s.hit = (s.grp == '0);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  input  logic         wr_edge_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] edge_o,
  output logic [W-1:0] evt_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] prev_q;
  logic [W-1:0] fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      fall_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
      if (wr_edge_i) fall_q <= wdata_i;
    end
  end

  // Per-pin polarity choice: 0 = rising, 1 = falling.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign evt_o[i] = fall_q[i] ? (prev_q[i] & ~sync_q[i])
                                : (sync_q[i] & ~prev_q[i]);
  end

  assign edge_o = fall_q;

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         wr_stat_i,
  input  logic         wr_mask_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         act_o
);

  logic [W-1:0] stat_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] clr;

  assign clr = wr_stat_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      // A new event wins over a simultaneous clear.
      stat_q <= (stat_q & ~clr) | evt_i;
      if (wr_mask_i) mask_q <= wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign act_o  = |(stat_q & mask_q);

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_agg_pkg::*;
#(
  parameter int unsigned REG_W     = 8,
  parameter int unsigned GPIO_GRPS = 3,
  localparam int unsigned NGRP     = GPIO_GRPS + 1
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 rd_en,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [NGRP-1:0][REG_W-1:0]           stat_g,
  input  logic [NGRP-1:0][REG_W-1:0]           mask_g,
  input  logic [GPIO_GRPS-1:0][REG_W-1:0]      edge_g,
  input  logic [NGRP-1:0]                      grp_act,
  output logic [REG_W-1:0]                     rd_data,
  output logic                                 rd_valid
);

  reg_sel_t         rsel;
  logic [REG_W-1:0] rmux;

  always_comb begin
    rsel = decode_addr(addr, GPIO_GRPS);
    rmux = '0;
    if (rsel.hit) begin
      unique case (rsel.kind)
        K_STAT: for (int g = 0; g < NGRP; g++)
                  if (rsel.grp == GRP_IDX_W'(g)) rmux = stat_g[g];
        K_MASK: for (int g = 0; g < NGRP; g++)
                  if (rsel.grp == GRP_IDX_W'(g)) rmux = mask_g[g];
        K_EDGE: for (int g = 0; g < GPIO_GRPS; g++)
                  if (rsel.grp == GRP_IDX_W'(g)) rmux = edge_g[g];
        default: rmux = REG_W'(grp_act);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rmux;
    end
  end

endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned REG_W     = 8,
  parameter int unsigned GPIO_GRPS = 3,
  localparam int unsigned NGRP     = GPIO_GRPS + 1,
  localparam int unsigned NPIN     = GPIO_GRPS * REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   gpio_in,
  input  logic [REG_W-1:0]  kbd_evt,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic              irq_n
);

  logic [NGRP-1:0][REG_W-1:0]      stat_g;
  logic [NGRP-1:0][REG_W-1:0]      mask_g;
  logic [NGRP-1:0][REG_W-1:0]      evt_g;
  logic [GPIO_GRPS-1:0][REG_W-1:0] edge_g;
  logic [NGRP-1:0]                 grp_act;
  logic [NGRP-1:0]                 wr_stat;
  logic [NGRP-1:0]                 wr_mask;
  reg_sel_t                        wsel;

  // Flat views for the bound checker.
  logic [NGRP*REG_W-1:0] stat_all;
  logic [NGRP*REG_W-1:0] mask_all;
  logic [NGRP*REG_W-1:0] evt_all;

  assign wsel     = decode_addr(addr, GPIO_GRPS);
  assign stat_all = stat_g;
  assign mask_all = mask_g;
  assign evt_all  = evt_g;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign wr_stat[g] = wr_en && wsel.hit && (wsel.kind == K_STAT)
                        && (wsel.grp == GRP_IDX_W'(g));
    assign wr_mask[g] = wr_en && wsel.hit && (wsel.kind == K_MASK)
                        && (wsel.grp == GRP_IDX_W'(g));

    if (g < GPIO_GRPS) begin : g_gpio
      logic wr_edge;
      assign wr_edge = wr_en && wsel.hit && (wsel.kind == K_EDGE)
                       && (wsel.grp == GRP_IDX_W'(g));
      irq_edge_sync #(.W(REG_W)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (gpio_in[g*REG_W +: REG_W]),
        .wr_edge_i (wr_edge),
        .wdata_i   (wr_data),
        .edge_o    (edge_g[g]),
        .evt_o     (evt_g[g])
      );
    end else begin : g_kbd
      assign evt_g[g] = kbd_evt;
    end

    irq_status_bank #(.W(REG_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .evt_i     (evt_g[g]),
      .wr_stat_i (wr_stat[g]),
      .wr_mask_i (wr_mask[g]),
      .wdata_i   (wr_data),
      .stat_o    (stat_g[g]),
      .mask_o    (mask_g[g]),
      .act_o     (grp_act[g])
    );
  end

  irq_reg_port #(.REG_W(REG_W), .GPIO_GRPS(GPIO_GRPS)) u_port (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .stat_g   (stat_g),
    .mask_g   (mask_g),
    .edge_g   (edge_g),
    .grp_act  (grp_act),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~(|grp_act);
  end

endmodule

// File: rtl/irq_group_agg_chk.sv
module irq_group_agg_chk #(
  parameter int unsigned REG_W     = 8,
  parameter int unsigned GPIO_GRPS = 3,
  localparam int unsigned NB       = (GPIO_GRPS + 1) * REG_W
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          irq_n,
  input logic [NB-1:0] stat_all,
  input logic [NB-1:0] mask_all,
  input logic [NB-1:0] evt_all
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_n && !rd_valid && stat_all == '0 && mask_all == '0));

  p_irq_tracks_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_n == !$past(|(stat_all & mask_all))));

  p_event_sticks_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((stat_all & $past(evt_all)) == $past(evt_all)));

  p_set_needs_event_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((stat_all & ~$past(stat_all) & ~$past(evt_all)) == '0));

  p_read_latency_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_valid == $past(rd_en)));

endmodule

bind irq_group_agg irq_group_agg_chk #(.REG_W(REG_W), .GPIO_GRPS(GPIO_GRPS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .irq_n    (irq_n),
  .stat_all (stat_all),
  .mask_all (mask_all),
  .evt_all  (evt_all)
);

// File: tb/irq_group_agg_tb_top.sv
module irq_group_agg_tb_top;
  import irq_agg_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int REG_W      = 8;
  localparam int GPIO_GRPS  = 3;
  localparam int NPIN       = GPIO_GRPS * REG_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NPIN-1:0]   gpio_in = '0;
  logic [REG_W-1:0]  kbd_evt = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [REG_W-1:0]  wr_data = '0;
  logic [REG_W-1:0]  rd_data;
  logic              rd_valid;
  logic              irq_n;

  int checks = 0;
  int errors = 0;
  logic [REG_W-1:0] exp_q[$];
  string            tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_group_agg #(.REG_W(REG_W), .GPIO_GRPS(GPIO_GRPS)) dut_i (
    .clk(clk), .rst(rst), .gpio_in(gpio_in), .kbd_evt(kbd_evt),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq_n(irq_n)
  );

  // Monitor: pops one expected item per valid read result.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read result: rd_data=%h expected none", rd_data);
      end else begin
        automatic logic [REG_W-1:0] e = exp_q.pop_front();
        automatic string            t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: rd_data=%h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: issue a read and push its expected value to the scoreboard.
  task automatic rd(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] e,
                    input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_bit(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: value=%b expected %b", tag, act, e);
    end
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk);
    gpio_in[idx] = v;
    tick(4);
  endtask

  task automatic kbd_pulse(input logic [REG_W-1:0] v);
    @(negedge clk);
    kbd_evt = v;
    @(negedge clk);
    kbd_evt = '0;
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not finish, elapsed=%0t expected completion", $time);
    report();
    $finish;
  end

  initial begin
    tick(1);
    chk_bit(irq_n, 1'b1, "R1 irq_n during reset");
    tick(2);
    rst = 1'b0;
    tick(1);
    // R1: reset state
    chk_bit(irq_n, 1'b1, "R1 irq_n after reset");
    chk_bit(rd_valid, 1'b0, "R1 rd_valid after reset");
    for (int g = 0; g < 4; g++) rd(ADDR_W'(g), 8'h00, "R1 status reset");
    for (int g = 0; g < 4; g++) rd(ADDR_W'(8 + g), 8'h00, "R1 mask reset");
    for (int g = 0; g < 3; g++) rd(ADDR_W'(16 + g), 8'h00, "R1 edge reset");
    rd(5'd24, 8'h00, "R1 summary reset");

    // R2: rising edges set status, falling ignored
    set_pin(0, 1'b1);
    rd(5'd0, 8'h01, "R2 pin0 rise");
    set_pin(9, 1'b1);
    rd(5'd1, 8'h02, "R2 pin9 rise in group1");
    rd(5'd2, 8'h00, "R2 group2 untouched");
    wr(5'd0, 8'h01);
    rd(5'd0, 8'h00, "R5 clear pin0 bit");
    set_pin(0, 1'b0);
    rd(5'd0, 8'h00, "R2 pin0 fall ignored");

    // R3: falling edge select
    wr(5'd16, 8'h04);
    set_pin(2, 1'b1);
    rd(5'd0, 8'h00, "R3 pin2 rise ignored");
    set_pin(2, 1'b0);
    rd(5'd0, 8'h04, "R3 pin2 fall sets");

    // R5: write-zero keeps, write-one clears
    wr(5'd1, 8'h00);
    rd(5'd1, 8'h02, "R5 write zero keeps");
    wr(5'd1, 8'h02);
    rd(5'd1, 8'h00, "R5 write one clears");

    // R4: keyboard events
    kbd_pulse(8'h80);
    rd(5'd3, 8'h80, "R4 kbd status");
    rd(5'd0, 8'h04, "R4 gpio status untouched");

    // R7/R8: masking and summary
    tick(1);
    chk_bit(irq_n, 1'b1, "R7 masked status keeps irq high");
    rd(5'd24, 8'h00, "R8 summary all masked");
    wr(5'd11, 8'h80);
    tick(1);
    chk_bit(irq_n, 1'b0, "R7 kbd unmasked asserts");
    rd(5'd24, 8'h08, "R8 summary kbd");
    wr(5'd8, 8'h04);
    rd(5'd24, 8'h09, "R8 summary kbd and group0");
    wr(5'd3, 8'h80);
    tick(1);
    chk_bit(irq_n, 1'b0, "R7 group0 still active");
    rd(5'd24, 8'h01, "R8 summary group0");
    wr(5'd0, 8'h04);
    tick(1);
    chk_bit(irq_n, 1'b1, "R7 all cleared deasserts");
    rd(5'd24, 8'h00, "R8 summary cleared");

    // R9: readback, read-only and unmapped
    rd(5'd8, 8'h04, "R9 mask0 readback");
    rd(5'd11, 8'h80, "R9 kbd mask readback");
    rd(5'd16, 8'h04, "R9 edge0 readback");
    rd(5'd17, 8'h00, "R9 edge1 untouched");
    wr(5'd24, 8'hFF);
    rd(5'd24, 8'h00, "R9 summary write ignored");
    wr(5'd19, 8'hFF);
    rd(5'd19, 8'h00, "R9 unmapped edge addr");
    rd(5'd12, 8'h00, "R9 unmapped mask addr");
    rd(5'd4, 8'h00, "R9 unmapped status addr");
    rd(5'd25, 8'h00, "R9 unmapped high addr");
    tick(1);
    chk_bit(irq_n, 1'b1, "R9 unmapped write no irq");

    // R6: set wins over same-cycle clear
    kbd_pulse(8'h03);
    rd(5'd3, 8'h03, "R6 kbd bits set");
    @(negedge clk);
    kbd_evt = 8'h01; wr_en = 1'b1; addr = 5'd3; wr_data = 8'h03;
    @(negedge clk);
    kbd_evt = '0; wr_en = 1'b0;
    rd(5'd3, 8'h01, "R6 event beats clear");

    // R10: pin to irq latency
    wr(5'd3, 8'hFF);
    wr(5'd10, 8'h01);
    tick(1);
    chk_bit(irq_n, 1'b1, "R10 irq idle before edge");
    chk_bit(rd_valid, 1'b0, "R10 rd_valid idle");
    @(negedge clk);
    gpio_in[16] = 1'b1;
    tick(3);
    chk_bit(irq_n, 1'b1, "R10 irq not yet at third edge");
    tick(1);
    chk_bit(irq_n, 1'b0, "R10 irq at fourth edge");
    rd(5'd2, 8'h01, "R10 group2 status");
    rd(5'd24, 8'h04, "R8 summary group2");

    tick(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: pending=%0d expected 0", exp_q.size());
    end
    report();
    $finish;
  end

endmodule